// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a configurable two-level logic plane. Fourteen dedicated input signals and twelve feedback signals are each offered to the plane in two forms, true and complemented. A stored connection row per product term selects which of those literals the term ANDs together. The product terms are split into twelve groups of unequal size, and each group is ORed into one sum output. Software is expected to flatten any multi-level function into this single AND-then-OR shape before it writes the rows.

Connection rows are written one whole row at a time through an address/data port that is clocked. The path from the signal inputs to the sum outputs has no register in it. The only state in the block is the connection store. Reset clears every row.

Top module: `sop_array`

## Requirements
- R1: An active-low reset (`rst_n`) clears every connection row. With no row written since reset, all twelve sum outputs read 1 for any input values.
- R2: Row bit 2*s is the true literal of signal s, and row bit 2*s+1 is its complement. Signals 0 to 13 are `in_i[0]` to `in_i[13]`, and signals 14 to 25 are `fb_i[0]` to `fb_i[11]`. A product term is the AND of the literals whose row bits are 1.
- R3: A product term whose row is all zeros evaluates to 1.
- R4: A product term whose row has both bit 2*s and bit 2*s+1 set, for any signal s, evaluates to 0 for every input value.
- R5: The terms per output, from `sum_o[0]` to `sum_o[11]`, are 8, 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, 8. Term addresses are numbered consecutively, with output 0's group first, so output 1 starts at address 8 and output 11 ends at address 135. Each sum output is the OR of its group.
- R6: When `cfg_we` is 1 at a rising clock edge and `cfg_addr` is below 136, `cfg_data` becomes that term's row. The outputs use the old row up to that edge and the new row after it.
- R7: A write to an address of 136 or above changes no row and no output.
- R8: The sum outputs follow changes on `in_i` and `fb_i` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the connection store |
| rst_n | input | 1 | Asynchronous active-low reset; clears all rows |
| in_i | input | 14 | Dedicated input signals |
| fb_i | input | 12 | Feedback signals |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 8 | Product term address of the row write |
| cfg_data | input | 52 | Connection row, two bits per signal |
| sum_o | output | 12 | OR of each output's product-term group |

## Verification
A row write and the evaluation of that same row's output can happen in the same cycle. The bench holds `cfg_we` with a new row for a term of output 0 across one clock edge while the inputs stay fixed. It checks that `sum_o[0]` still shows the old row's value after the write is set up but before the edge, and shows the new row's value after the edge. All other vectors are judged against a hand-derived table of expected sums. Before that table is applied, every unused term is filled with a contradictory row.

// File: rtl/sop_pkg.sv
package sop_pkg;
   localparam int CNT_W = 8;

   // position of a literal inside a connection row
   function automatic int lit_pos(input int sig, input bit neg);
      return 2 * sig + (neg ? 1 : 0);
   endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
   parameter int N_TERMS = 136,
   parameter int LIT_W   = 52,
   parameter int ADDR_W  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [LIT_W-1:0]                data,
   output logic [N_TERMS-1:0][LIT_W-1:0]   rows
);
   for (genvar t = 0; t < N_TERMS; t++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rows[t] <= '0;
         else if (we && addr == ADDR_W'(t))
            rows[t] <= data;
      end
   end
endmodule

// File: rtl/sop_term.sv
module sop_term #(
   parameter int LIT_W = 52
) (
   input  logic [LIT_W-1:0] row,
   input  logic [LIT_W-1:0] lits,
   output logic             term
);
   // an unconnected literal contributes 1 to the AND
   always_comb term = &(~row | lits);
endmodule

// File: rtl/sop_or_group.sv
module sop_or_group #(
   parameter int N_TERMS = 136,
   parameter int BASE    = 0,
   parameter int CNT     = 8
) (
   input  logic [N_TERMS-1:0] terms,
   output logic               sum
);
   always_comb sum = |terms[BASE +: CNT];
endmodule

// File: rtl/sop_array.sv
module sop_array
   import sop_pkg::*;
#(
   parameter int N_DED = 14,
   parameter int N_FB  = 12,
   parameter int N_OUT = 12,
   parameter logic [N_OUT-1:0][CNT_W-1:0] TERM_CNT =
      {8'd8, 8'd8, 8'd10, 8'd12, 8'd14, 8'd16, 8'd16, 8'd14, 8'd12, 8'd10, 8'd8, 8'd8},
   parameter int ADDR_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_DED-1:0]     in_i,
   input  logic [N_FB-1:0]      fb_i,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_addr,
   input  logic [2*(N_DED+N_FB)-1:0] cfg_data,
   output logic [N_OUT-1:0]     sum_o
);
   function automatic int base_of(input int k);
      int acc = 0;
      for (int j = 0; j < k; j++) acc += int'(TERM_CNT[j]);
      return acc;
   endfunction

   localparam int N_SIG   = N_DED + N_FB;
   localparam int LIT_W   = 2 * N_SIG;
   localparam int N_TERMS = base_of(N_OUT);

   if (N_DED < 1 || N_FB < 0 || N_OUT < 1) begin : g_bad_dims
      $error("sop_array: bad signal or output count");
   end
   if (N_TERMS > (1 << ADDR_W)) begin : g_bad_addr
      $error("sop_array: ADDR_W too narrow for %0d terms", N_TERMS);
   end
   for (genvar k = 0; k < N_OUT; k++) begin : g_chk_cnt
      if (TERM_CNT[k] == 0) begin : g_zero
         $error("sop_array: output %0d has no product terms", k);
      end
   end

   logic [N_SIG-1:0]                sig;
   logic [LIT_W-1:0]                lits;
   logic [N_TERMS-1:0][LIT_W-1:0]   cfg_rows;
   logic [N_TERMS-1:0]              terms;

   always_comb sig = {fb_i, in_i};

   for (genvar s = 0; s < N_SIG; s++) begin : g_lit
      assign lits[lit_pos(s, 1'b0)] = sig[s];
      assign lits[lit_pos(s, 1'b1)] = ~sig[s];
   end

   sop_cfg_store #(
      .N_TERMS (N_TERMS),
      .LIT_W   (LIT_W),
      .ADDR_W  (ADDR_W)
   ) i_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .data  (cfg_data),
      .rows  (cfg_rows)
   );

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      sop_term #(.LIT_W(LIT_W)) i_term (
         .row  (cfg_rows[t]),
         .lits (lits),
         .term (terms[t])
      );
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      sop_or_group #(
         .N_TERMS (N_TERMS),
         .BASE    (base_of(k)),
         .CNT     (int'(TERM_CNT[k]))
      ) i_grp (
         .terms (terms),
         .sum   (sum_o[k])
      );
   end
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
   parameter int N_TERMS = 136,
   parameter int LIT_W   = 52,
   parameter int ADDR_W  = 8,
   parameter int N_OUT   = 12
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cfg_we,
   input logic [ADDR_W-1:0]               cfg_addr,
   input logic [LIT_W-1:0]                cfg_data,
   input logic [N_OUT-1:0]                sum_o,
   input logic [N_TERMS-1:0][LIT_W-1:0]   rows,
   input logic [N_TERMS-1:0]              terms
);
   function automatic logic [LIT_W-1:0] even_mask();
      logic [LIT_W-1:0] m = '0;
      for (int i = 0; i < LIT_W; i += 2) m[i] = 1'b1;
      return m;
   endfunction
   localparam logic [LIT_W-1:0] EVEN_MASK = even_mask();

   a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sum_o == '1));

   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_addr) < N_TERMS)) |=> (rows[$past(cfg_addr)] == $past(cfg_data)));

   a_r7_rows_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && (int'(cfg_addr) < N_TERMS)) |=> $stable(rows));

   for (genvar t = 0; t < N_TERMS; t++) begin : g_t
      a_r3_empty_true: assert property (@(posedge clk) disable iff (!rst_n)
         (rows[t] == '0) |-> terms[t]);
      a_r4_conflict_false: assert property (@(posedge clk) disable iff (!rst_n)
         (|(rows[t] & (rows[t] >> 1) & EVEN_MASK)) |-> !terms[t]);
   end
endmodule

bind sop_array sop_array_chk #(
   .N_TERMS (N_TERMS),
   .LIT_W   (LIT_W),
   .ADDR_W  (ADDR_W),
   .N_OUT   (N_OUT)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_data (cfg_data),
   .sum_o    (sum_o),
   .rows     (cfg_rows),
   .terms    (terms)
);

// File: tb/test_sop_array.sv
module test_sop_array;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] in_i = '0;
   logic [11:0] fb_i = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [51:0] cfg_data = '0;
   logic [11:0] sum_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sop_array i_sop_array (
      .clk(clk), .rst_n(rst_n), .in_i(in_i), .fb_i(fb_i),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .sum_o(sum_o)
   );

   typedef struct packed {
      logic [13:0] vin;
      logic [11:0] vfb;
      logic [11:0] vexp;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{14'h0000, 12'h000, 12'h802},
      '{14'h0001, 12'h000, 12'h803},
      '{14'h0003, 12'h001, 12'h803},
      '{14'h2003, 12'h800, 12'h000},
      '{14'h001C, 12'h000, 12'h822},
      '{14'h3FFF, 12'hFFF, 12'h061},
      '{14'h3FFF, 12'h7FF, 12'h821},
      '{14'h1FFD, 12'h000, 12'h823}
   };

   function automatic logic [51:0] lit(input int s, input bit neg);
      return 52'd1 << (2 * s + (neg ? 1 : 0));
   endfunction

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: sum_o=%h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [51:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state, all terms empty so every output is 1
      in_i = 14'h3FFF; fb_i = 12'h555;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2 check("R1", sum_o, 12'hFFF);
      in_i = 14'h0000; fb_i = 12'h000;
      #2 check("R1/R3", sum_o, 12'hFFF);

      // kill every term with a contradictory row (R4)
      for (int a = 0; a < 136; a++) wr(8'(a), 52'h3);
      #2 check("R4", sum_o, 12'h000);

      // R2/R5: program a few terms at group boundaries
      wr(8'd0,   lit(0, 0) | lit(1, 1));                 // out0: in0 & ~in1
      wr(8'd1,   lit(14, 0));                            // out0: fb0
      wr(8'd8,   lit(13, 1));                            // out1: ~in13
      wr(8'd67,  lit(2, 0) | lit(3, 0) | lit(4, 0));     // out5 last term
      begin
         logic [51:0] all_true = '0;
         for (int s = 0; s < 26; s++) all_true |= lit(s, 0);
         wr(8'd68, all_true);                            // out6 first term
      end
      wr(8'd135, lit(25, 1));                            // out11 last term: ~fb11

      // R2/R5/R8: table of vectors, inputs changed mid-cycle
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         #3 in_i = VECS[i].vin; fb_i = VECS[i].vfb;
         #2 check("R2/R5", sum_o, VECS[i].vexp);
      end

      // R8: output follows an input change with no edge between
      @(negedge clk);
      in_i = 14'h0000; fb_i = 12'h000;
      #2 check("R8", sum_o, 12'h802);
      #3 in_i = 14'h2000;
      #2 check("R8", sum_o, 12'h800);

      // R4: contradictory extra term in out1 never sets it
      wr(8'd9, lit(1, 0) | lit(1, 1));
      in_i = 14'h2000;
      #2 check("R4", sum_o, 12'h800);
      in_i = 14'h2002;
      #2 check("R4", sum_o, 12'h800);

      // R3: an empty row forces its output high
      wr(8'd10, 52'h0);
      #2 check("R3", sum_o, 12'h802);
      wr(8'd10, 52'h3);
      #2 check("R3", sum_o, 12'h800);

      // R7: out-of-range addresses change nothing
      wr(8'd136, 52'h0);
      #2 check("R7", sum_o, 12'h800);
      wr(8'd255, 52'h0);
      #2 check("R7", sum_o, 12'h800);

      // R6: write and evaluation in the same cycle
      @(negedge clk);
      in_i = 14'h2020;
      cfg_we = 1'b1; cfg_addr = 8'd2; cfg_data = lit(5, 0);   // out0: in5
      #2 check("R6 before edge", sum_o, 12'h800);
      @(negedge clk);
      cfg_we = 1'b0;
      #2 check("R6 after edge", sum_o, 12'h801);

      // R1: reset again mid-run clears all rows
      @(negedge clk);
      rst_n = 1'b0;
      #2 check("R1", sum_o, 12'hFFF);
      @(negedge clk);
      rst_n = 1'b1;
      in_i = 14'h0000;
      #2 check("R1", sum_o, 12'hFFF);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule